// File: doc/BRIEF.md
# Super I/O configuration port controller

This block is the configuration front end of a legacy-style I/O controller that sits on a byte-wide I/O bus. While locked, it watches byte writes to a fixed key port at address 0x2E. A correct four-byte key unlocks an indexed register space. The last key byte chooses where the index/data port pair appears: at 0x2E/0x2F or at 0x4E/0x4F.

Once unlocked, software writes a register number to the index port and then reads or writes the selected register through the data port. Registers below 0x30 are global. Register 0x30 is banked: it acts on the logical device whose number is held in global register 0x07.

A chip-select register compares one bit with a strap input. This lets one of two controllers on the same bus keep out of configuration. A dedicated exit code written to the control register locks the block again. The decoded results drive the device enables, the clock-select bit and the chip-match output.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset, configuration mode is off, cfg_base_hi is 0, dev_act is all zero, clk24_sel is 0, the logical device number is 0 and chip_match is 1. Every read returns 0xFF.
- R2: Writing 0x87, 0x01, 0x55, 0x55 in order to address 0x2E turns configuration mode on with cfg_base_hi = 0. The index port is then 0x2E and the data port is 0x2F.
- R3: The key 0x87, 0x01, 0x55, 0xAA turns configuration mode on with cfg_base_hi = 1. The index port is then 0x4E and the data port 0x4F, and accesses to 0x2E/0x2F read 0xFF and have no effect.
- R4: A byte that breaks the key sequence returns the matcher to idle. If that byte is 0x87, the matcher instead treats it as the first key byte, so 0x87 0x87 0x01 0x55 0x55 unlocks.
- R5: While configuration mode is off, writes to the index and data ports change no register and no output, and every read returns 0xFF.
- R6: Global register 0x07 holds the logical device number and reads back its full byte. Writing register 0x30 sets dev_act[n] to bit 0 of the written value for the current device number n, as long as n < NUM_LDN. Other devices keep their bits. A device number of NUM_LDN or more writes nothing, and reading 0x30 under it returns 0x00.
- R7: Bit 0 of global register 0x23 drives clk24_sel, where 1 selects the 24 MHz input and 0 the 48 MHz input. A read returns 0x00 or 0x01.
- R8: Until register 0x22 is written, chip_match is 1. After a write, chip_match equals (bit 7 of 0x22) == chip_strap. While chip_match is 0, data port writes to any register other than 0x22 are ignored, including the exit code, and data port reads return 0xFF. Reading 0x22 returns bit 7 in place and zeros elsewhere.
- R9: Bit 0 of global register 0x24 is a suspend flag. It reads 1 after reset, takes bit 0 of each write, and reads back as 0x00 or 0x01.
- R10: Writing 0x02 to register 0x02 while chip_match is 1 turns configuration mode off. Any other value written there has no effect, and register 0x02 reads 0x00. dev_act and clk24_sel keep their values after the exit, and the full key is needed to unlock again.
- R11: In configuration mode, a read of the index port returns the last index written. Registers with no function read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational; 0xFF when not decoded |
| chip_strap | input | 1 | Strap level compared with bit 7 of register 0x22 |
| cfg_mode | output | 1 | Configuration mode is on |
| cfg_base_hi | output | 1 | 1: index/data at 0x4E/0x4F, 0: at 0x2E/0x2F |
| chip_match | output | 1 | This chip accepts configuration |
| dev_act | output | NUM_LDN | Activate bit for each logical device |
| clk24_sel | output | 1 | Input clock select, 1 = 24 MHz |

## Verification
The bench feeds broken keys, some with a stray 0x87 in the middle. A matcher that drops 0x87 back to idle, or that keeps its partial progress across a wrong byte, would unlock at the wrong time. It writes the activate register under device numbers at and above NUM_LDN, and a loose bank decode would then alias onto a real device. It sets register 0x22 against the strap and then tries every register, including the exit code; a design that gated only some writes would change clk24_sel or drop out of configuration mode. After an exit, and under the high base, it probes the old port pair, where a stale decode would return live data instead of 0xFF.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    // unlock key bytes
    localparam logic [7:0] KEY_B0    = 8'h87;
    localparam logic [7:0] KEY_B1    = 8'h01;
    localparam logic [7:0] KEY_B2    = 8'h55;
    localparam logic [7:0] KEY_LO    = 8'h55;
    localparam logic [7:0] KEY_HI    = 8'hAA;

    // register indices
    localparam logic [7:0] IX_CTRL   = 8'h02;
    localparam logic [7:0] IX_LDN    = 8'h07;
    localparam logic [7:0] IX_CHSEL  = 8'h22;
    localparam logic [7:0] IX_CLK    = 8'h23;
    localparam logic [7:0] IX_SUSP   = 8'h24;
    localparam logic [7:0] IX_ACT    = 8'h30;
    localparam logic [7:0] EXIT_CODE = 8'h02;

    typedef enum logic [1:0] {
        KEY_IDLE,
        KEY_GOT1,
        KEY_GOT2,
        KEY_GOT3
    } key_stage_e;

endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    input  logic       exit_req,
    output logic       cfg_on,
    output logic       base_hi
);

    typedef struct packed {
        key_stage_e stage;
        logic       on;
        logic       hi;
    } key_st_t;

    key_st_t st_d, st_q;
    key_stage_e restart;

    always_comb begin
        st_d    = st_q;
        restart = (key_byte == KEY_B0) ? KEY_GOT1 : KEY_IDLE;
        if (exit_req) begin
            st_d.on    = 1'b0;
            st_d.stage = KEY_IDLE;
        end else if (key_wr && !st_q.on) begin
            case (st_q.stage)
                KEY_IDLE: st_d.stage = restart;
                KEY_GOT1: st_d.stage = (key_byte == KEY_B1) ? KEY_GOT2 : restart;
                KEY_GOT2: st_d.stage = (key_byte == KEY_B2) ? KEY_GOT3 : restart;
                default: begin
                    if (key_byte == KEY_LO || key_byte == KEY_HI) begin
                        st_d.on    = 1'b1;
                        st_d.hi    = (key_byte == KEY_HI);
                        st_d.stage = KEY_IDLE;
                    end else begin
                        st_d.stage = restart;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{stage: KEY_IDLE, on: 1'b0, hi: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_on  = st_q.on;
    assign base_hi = st_q.hi;

    // R2
    cfg_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.on) |-> $past(key_wr) &&
            ($past(key_byte) == KEY_LO || $past(key_byte) == KEY_HI));

    // R10
    cfg_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |=> !st_q.on);

    // R4
    key_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && !st_q.on && !exit_req && key_byte == KEY_B0) |=> st_q.stage == KEY_GOT1);

endmodule

// File: rtl/sio_reg_file.sv
module sio_reg_file
    import sio_cfg_pkg::*;
#(
    parameter int unsigned NUM_LDN = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idx_wr,
    input  logic               dat_wr,
    input  logic [7:0]         wdata,
    input  logic               strap,
    output logic [7:0]         idx_o,
    output logic [7:0]         dat_rd,
    output logic [NUM_LDN-1:0] act_o,
    output logic               clk24_o,
    output logic               match_o,
    output logic               exit_req
);

    typedef struct packed {
        logic [7:0]         idx;
        logic [7:0]         ldn;
        logic               sel_seen;
        logic               sel_bit;
        logic               clk24;
        logic               susp;
        logic [NUM_LDN-1:0] act;
    } reg_st_t;

    reg_st_t rf_d, rf_q;
    logic match;
    logic wr_ok;
    logic [NUM_LDN-1:0] act_hit;

    assign match = !rf_q.sel_seen || (rf_q.sel_bit == strap);
    assign wr_ok = dat_wr && (match || rf_q.idx == IX_CHSEL);

    // per-device bank selection for read-back
    for (genvar g = 0; g < NUM_LDN; g++) begin : g_bank
        assign act_hit[g] = (rf_q.ldn == 8'(g)) && rf_q.act[g];
    end

    always_comb begin
        rf_d = rf_q;
        if (idx_wr) begin
            rf_d.idx = wdata;
        end
        if (wr_ok) begin
            case (rf_q.idx)
                IX_LDN:   rf_d.ldn = wdata;
                IX_CHSEL: begin
                    rf_d.sel_seen = 1'b1;
                    rf_d.sel_bit  = wdata[7];
                end
                IX_CLK:   rf_d.clk24 = wdata[0];
                IX_SUSP:  rf_d.susp  = wdata[0];
                IX_ACT: begin
                    for (int i = 0; i < NUM_LDN; i++) begin
                        if (rf_q.ldn == 8'(i)) begin
                            rf_d.act[i] = wdata[0];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '{idx: 8'h00, ldn: 8'h00, sel_seen: 1'b0, sel_bit: 1'b0,
                      clk24: 1'b0, susp: 1'b1, act: '0};
        end else begin
            rf_q <= rf_d;
        end
    end

    always_comb begin
        if (!match) begin
            dat_rd = 8'hFF;
        end else begin
            case (rf_q.idx)
                IX_LDN:   dat_rd = rf_q.ldn;
                IX_CHSEL: dat_rd = {rf_q.sel_bit, 7'b0};
                IX_CLK:   dat_rd = {7'b0, rf_q.clk24};
                IX_SUSP:  dat_rd = {7'b0, rf_q.susp};
                IX_ACT:   dat_rd = {7'b0, |act_hit};
                default:  dat_rd = 8'h00;
            endcase
        end
    end

    assign exit_req = dat_wr && match && rf_q.idx == IX_CTRL && wdata == EXIT_CODE;
    assign idx_o    = rf_q.idx;
    assign act_o    = rf_q.act;
    assign clk24_o  = rf_q.clk24;
    assign match_o  = match;

    // R8
    nomatch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !match && rf_q.idx != IX_CHSEL) |=>
            $stable(rf_q.clk24) && $stable(rf_q.ldn) && $stable(rf_q.act) && $stable(rf_q.susp));

    // R7
    clk_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rf_q.clk24) |-> $past(dat_wr) && $past(rf_q.idx) == IX_CLK);

    // R6
    act_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rf_q.act) |-> $past(dat_wr) && $past(rf_q.idx) == IX_ACT &&
            $countones(rf_q.act ^ $past(rf_q.act)) == 1);

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int unsigned        ADDR_W   = 16,
    parameter int unsigned        NUM_LDN  = 4,
    parameter logic [ADDR_W-1:0]  KEY_PORT = 'h2E,
    parameter logic [ADDR_W-1:0]  BASE_LO  = 'h2E,
    parameter logic [ADDR_W-1:0]  BASE_HI  = 'h4E
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [7:0]         io_wdata,
    output logic [7:0]         io_rdata,
    input  logic               chip_strap,
    output logic               cfg_mode,
    output logic               cfg_base_hi,
    output logic               chip_match,
    output logic [NUM_LDN-1:0] dev_act,
    output logic               clk24_sel
);

    logic              cfg_on, base_hi, exit_req;
    logic [ADDR_W-1:0] idx_addr, dat_addr;
    logic              idx_hit, dat_hit, key_wr;
    logic [7:0]        idx_val, dat_val;

    assign idx_addr = base_hi ? BASE_HI : BASE_LO;
    assign dat_addr = idx_addr + ADDR_W'(1);
    assign idx_hit  = cfg_on && io_addr == idx_addr;
    assign dat_hit  = cfg_on && io_addr == dat_addr;
    assign key_wr   = io_wr && !cfg_on && io_addr == KEY_PORT;

    sio_key_fsm i_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_byte (io_wdata),
        .exit_req (exit_req),
        .cfg_on   (cfg_on),
        .base_hi  (base_hi)
    );

    sio_reg_file #(.NUM_LDN(NUM_LDN)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (io_wr && idx_hit),
        .dat_wr   (io_wr && dat_hit),
        .wdata    (io_wdata),
        .strap    (chip_strap),
        .idx_o    (idx_val),
        .dat_rd   (dat_val),
        .act_o    (dev_act),
        .clk24_o  (clk24_sel),
        .match_o  (chip_match),
        .exit_req (exit_req)
    );

    always_comb begin
        if (io_rd && idx_hit) begin
            io_rdata = idx_val;
        end else if (io_rd && dat_hit) begin
            io_rdata = dat_val;
        end else begin
            io_rdata = 8'hFF;
        end
    end

    assign cfg_mode    = cfg_on;
    assign cfg_base_hi = base_hi;

    // R5
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !cfg_on) |-> io_rdata == 8'hFF);

    // R5
    idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !cfg_on) |=> $stable(dev_act) && $stable(clk24_sel));

endmodule

// File: tb/test_sio_cfg_port.sv
`timescale 1ns/1ps
module test_sio_cfg_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic        chip_strap = 1'b0;
    logic        cfg_mode, cfg_base_hi, chip_match, clk24_sel;
    logic [3:0]  dev_act;

    int total = 0;
    int bad = 0;

    // reference state, built from the requirements
    bit       m_on, m_hi, m_seen, m_selb, m_clk, m_susp;
    int       m_stage;
    bit [7:0] m_idx, m_ldn;
    bit [3:0] m_act;

    always #2.5 clk = ~clk;

    sio_cfg_port i_sio_cfg_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .io_addr     (io_addr),
        .io_wr       (io_wr),
        .io_rd       (io_rd),
        .io_wdata    (io_wdata),
        .io_rdata    (io_rdata),
        .chip_strap  (chip_strap),
        .cfg_mode    (cfg_mode),
        .cfg_base_hi (cfg_base_hi),
        .chip_match  (chip_match),
        .dev_act     (dev_act),
        .clk24_sel   (clk24_sel)
    );

    function automatic bit m_match();
        return !m_seen || (m_selb == chip_strap);
    endfunction

    function automatic bit [15:0] m_base();
        return m_hi ? 16'h004E : 16'h002E;
    endfunction

    task automatic m_reset();
        m_on = 0; m_hi = 0; m_seen = 0; m_selb = 0; m_clk = 0; m_susp = 1;
        m_stage = 0; m_idx = 0; m_ldn = 0; m_act = 0;
    endtask

    task automatic m_write(input bit [15:0] a, input bit [7:0] d);
        bit [7:0] key [3];
        key[0] = 8'h87; key[1] = 8'h01; key[2] = 8'h55;
        if (!m_on) begin
            if (a == 16'h002E) begin
                if (m_stage == 3) begin
                    if (d == 8'h55 || d == 8'hAA) begin
                        m_on = 1; m_hi = (d == 8'hAA); m_stage = 0;
                    end else begin
                        m_stage = (d == 8'h87) ? 1 : 0;
                    end
                end else if (d == key[m_stage]) begin
                    m_stage = m_stage + 1;
                end else begin
                    m_stage = (d == 8'h87) ? 1 : 0;
                end
            end
        end else if (a == m_base()) begin
            m_idx = d;
        end else if (a == m_base() + 16'd1) begin
            if (m_idx == 8'h22) begin
                m_seen = 1; m_selb = d[7];
            end else if (m_match()) begin
                case (m_idx)
                    8'h02: if (d == 8'h02) begin m_on = 0; m_stage = 0; end
                    8'h07: m_ldn = d;
                    8'h23: m_clk = d[0];
                    8'h24: m_susp = d[0];
                    8'h30: if (m_ldn < 4) m_act[m_ldn[1:0]] = d[0];
                    default: ;
                endcase
            end
        end
    endtask

    function automatic bit [7:0] m_read(input bit [15:0] a);
        if (!m_on) return 8'hFF;
        if (a == m_base()) return m_idx;
        if (a != m_base() + 16'd1) return 8'hFF;
        if (!m_match()) return 8'hFF;
        case (m_idx)
            8'h07: return m_ldn;
            8'h22: return {m_selb, 7'b0};
            8'h23: return {7'b0, m_clk};
            8'h24: return {7'b0, m_susp};
            8'h30: return (m_ldn < 4) ? {7'b0, m_act[m_ldn[1:0]]} : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input bit [15:0] a, input bit [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        m_write(a, d);
    endtask

    task automatic rd(input string req, input bit [15:0] a);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        chk(req, {24'h0, io_rdata}, {24'h0, m_read(a)});
        io_rd = 1'b0;
    endtask

    task automatic outs(input string req);
        #0.5;
        chk({req, " cfg_mode"},   {31'h0, cfg_mode},    {31'h0, m_on});
        chk({req, " base_hi"},    {31'h0, cfg_base_hi}, {31'h0, m_hi});
        chk({req, " chip_match"}, {31'h0, chip_match},  {31'h0, m_match()});
        chk({req, " dev_act"},    {28'h0, dev_act},     {28'h0, m_act});
        chk({req, " clk24_sel"},  {31'h0, clk24_sel},   {31'h0, m_clk});
    endtask

    task automatic key(input bit hi);
        wr(16'h2E, 8'h87); wr(16'h2E, 8'h01); wr(16'h2E, 8'h55);
        wr(16'h2E, hi ? 8'hAA : 8'h55);
    endtask

    task automatic reg_wr(input bit [7:0] ix, input bit [7:0] d);
        wr(m_base(), ix);
        wr(m_base() + 16'd1, d);
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit [15:0] addrs [5];
        bit [7:0]  picks [9];
        addrs = '{16'h2E, 16'h2F, 16'h4E, 16'h4F, 16'h60};
        picks = '{8'h87, 8'h01, 8'h55, 8'h02, 8'h07, 8'h22, 8'h23, 8'h24, 8'h30};
        void'($urandom(32'd4711));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        outs("R1");
        chk("R1 cfg off", {31'h0, cfg_mode}, 32'h0);
        rd("R1 rd 2F", 16'h2F);
        rd("R1 rd 4F", 16'h4F);

        // R5 writes while locked
        wr(16'h2F, 8'h23); wr(16'h4F, 8'h01); wr(16'h4E, 8'h30);
        outs("R5");
        rd("R5 rd 2E", 16'h2E);

        // R4 broken key, then 0x87 restart
        wr(16'h2E, 8'h87); wr(16'h2E, 8'h01); wr(16'h2E, 8'h55); wr(16'h2E, 8'h12);
        chk("R4 broken key stays locked", {31'h0, cfg_mode}, 32'h0);
        wr(16'h2E, 8'h87); wr(16'h2E, 8'h87); wr(16'h2E, 8'h01);
        wr(16'h2E, 8'h55); wr(16'h2E, 8'h55);
        chk("R4 repeated 87 unlocks", {31'h0, cfg_mode}, 32'h1);
        chk("R2 base low", {31'h0, cfg_base_hi}, 32'h0);
        outs("R2");

        // R11 index readback
        wr(16'h2E, 8'h23);
        rd("R11 index readback", 16'h2E);
        reg_wr(8'h5A, 8'h77);
        rd("R11 unused reg reads 0", 16'h2F);

        // R7 clock select
        reg_wr(8'h23, 8'h01);
        chk("R7 clk24_sel set", {31'h0, clk24_sel}, 32'h1);
        rd("R7 readback", 16'h2F);

        // R6 banked activate
        reg_wr(8'h07, 8'h02); reg_wr(8'h30, 8'h01);
        chk("R6 dev2 active", {28'h0, dev_act}, 32'h4);
        reg_wr(8'h07, 8'h00); reg_wr(8'h30, 8'hFF);
        chk("R6 dev0 active", {28'h0, dev_act}, 32'h5);
        rd("R6 act readback", 16'h2F);
        reg_wr(8'h07, 8'h09); reg_wr(8'h30, 8'h01);
        chk("R6 out of range ignored", {28'h0, dev_act}, 32'h5);
        rd("R6 out of range reads 0", 16'h2F);
        wr(16'h2E, 8'h07);
        rd("R6 ldn readback", 16'h2F);

        // R9 suspend flag
        wr(16'h2E, 8'h24);
        rd("R9 suspend reset 1", 16'h2F);
        reg_wr(8'h24, 8'h00);
        rd("R9 suspend cleared", 16'h2F);

        // R10 exit
        reg_wr(8'h02, 8'h01);
        chk("R10 wrong code stays", {31'h0, cfg_mode}, 32'h1);
        rd("R10 ctrl reads 0", 16'h2F);
        reg_wr(8'h02, 8'h02);
        chk("R10 exit", {31'h0, cfg_mode}, 32'h0);
        outs("R10 retained");
        rd("R10 locked read", 16'h2F);

        // R3 high base
        key(1'b1);
        outs("R3");
        chk("R3 base high", {31'h0, cfg_base_hi}, 32'h1);
        wr(16'h2E, 8'h23); wr(16'h2F, 8'h00);
        chk("R3 old pair ignored", {31'h0, clk24_sel}, 32'h1);
        rd("R3 old pair reads FF", 16'h2F);
        reg_wr(8'h23, 8'h00);
        rd("R3 new pair works", 16'h4F);

        // R8 chip select against strap
        chip_strap = 1'b0;
        reg_wr(8'h22, 8'h80);
        outs("R8 mismatch");
        chk("R8 match low", {31'h0, chip_match}, 32'h0);
        reg_wr(8'h23, 8'h01);
        chk("R8 write ignored", {31'h0, clk24_sel}, 32'h0);
        rd("R8 reads FF", 16'h4F);
        reg_wr(8'h02, 8'h02);
        chk("R8 exit ignored", {31'h0, cfg_mode}, 32'h1);
        chip_strap = 1'b1;
        outs("R8 strap match");
        wr(16'h4E, 8'h22);
        rd("R8 sel readback", 16'h4F);
        reg_wr(8'h02, 8'h02);
        outs("R10 exit after match");

        // random phase
        for (int it = 0; it < 1500; it++) begin
            int sel;
            bit [15:0] a;
            bit [7:0] d;
            sel = int'($urandom_range(0, 19));
            if (sel == 0) begin
                key(1'($urandom_range(0, 1)));
            end else if (sel == 1) begin
                @(negedge clk);
                chip_strap = ~chip_strap;
            end else begin
                a = addrs[$urandom_range(0, 4)];
                if ($urandom_range(0, 1) == 1) d = picks[$urandom_range(0, 8)];
                else d = 8'($urandom_range(0, 255));
                wr(a, d);
            end
            rd("R6 R8 R11 random read", addrs[$urandom_range(0, 4)]);
            if (it % 10 == 0) outs("R2 R3 random outputs");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule